// File: doc/BRIEF.md
# Three-Phase Hall Commutation Gate Logic

This block converts the three rotor-position sensor bits of a brushless motor into six switch commands for a three-phase bridge: one high-side and one low-side command per phase. A direction select flips which phase of the conducting pair is pulled high and which is pulled low. Brake, coast, undervoltage lockout, a digital PWM-on level, an overcurrent flag and a PWM cycle-start strobe then gate that pair before it is registered onto the outputs.

A mode select picks the chopping style. In two-quadrant mode PWM-off only drops the low-side switch of the pair. In four-quadrant mode it drops both switches. An overcurrent flag acts as pulse-by-pulse limiting: it holds the chopped switches off until the next cycle-start strobe. All analog comparison, sensing, oscillator timing and dead-time are done elsewhere, and their results reach this block as synchronous logic levels.

Top module: `bldc_commutator`

## Requirements
- R1: Sensor bits are read as `hall[2]`=A, `hall[1]`=B, `hall[0]`=C. Output bit 0 is phase A, bit 1 is B and bit 2 is C. With `dir_rev`=0 the high-low pairs are: 101 A-C, 100 A-B, 110 C-B, 010 C-A, 011 B-A, 001 B-C. Each output reflects the inputs sampled at the previous rising clock edge (one cycle of latency).
- R2: With `dir_rev`=1, each valid code drives the same pair with the high and low phases exchanged.
- R3: Codes 000 and 111 turn all six outputs off when brake is inactive.
- R4: When brake is active and nothing suppresses it, every high-side output is off and every low-side output is on, for any sensor code, direction or mode.
- R5: During brake, PWM-off or overcurrent turns every low-side output off, in both modes.
- R6: Coast turns all six outputs off, whatever the state of brake, sensors or PWM.
- R7: Undervoltage lockout turns all six outputs off, whatever the state of brake, sensors or PWM.
- R8: With `quad_mode`=0, PWM-off removes only the low-side command; the high-side command stays on.
- R9: With `quad_mode`=1, PWM-off removes both the high-side and the low-side command.
- R10: A sampled `oc_flag` acts as PWM-off in the same cycle and sets a hold. The hold keeps acting as PWM-off until an edge at which `cycle_start` is 1 and `oc_flag` is 0 clears it. That edge itself still outputs with the hold in force.
- R11: During reset, all outputs are 0 and the overcurrent hold is clear.
- R12: Outside brake, at most one high-side and at most one low-side output is on. A phase never has both its high-side and low-side outputs on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall | input | 3 | Sensor code, A in bit 2, C in bit 0 |
| dir_rev | input | 1 | 1 selects reverse decoding |
| brake | input | 1 | Brake request |
| coast | input | 1 | Coast request, disables all outputs |
| quad_mode | input | 1 | 0 chops low side only, 1 chops both sides |
| pwm_on | input | 1 | PWM comparator level, 1 = on-time |
| oc_flag | input | 1 | Overcurrent comparator level |
| uvlo | input | 1 | Undervoltage lockout active |
| cycle_start | input | 1 | One-cycle strobe at PWM period start |
| hi_drv | output | 3 | High-side commands, bit 0 = A |
| lo_drv | output | 3 | Low-side commands, bit 0 = A |

## Verification
The assertions assume every input is synchronous to `clk` and stable around the rising edge. The stimulus drives every input a quarter period after the edge and samples the outputs at that same point after the next edge. The assertions also treat `cycle_start` as a pulse that can coincide with `oc_flag`. The bench therefore includes a case where both are high together and checks that the hold survives it. The bench enters sensor codes in any order, including jumps and invalid codes, because the logic keeps no rotation history.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
  localparam int PHASES = 3;
  localparam int CODE_W = 3;

  typedef logic [PHASES-1:0] phase_t;

  typedef struct packed {
    phase_t hi;
    phase_t lo;
  } pair_t;

  // forward pair for a sensor code; bit0 = A, bit1 = B, bit2 = C
  function automatic pair_t decode_forward(input logic [CODE_W-1:0] code);
    pair_t p;
    p.hi = '0;
    p.lo = '0;
    case (code)
      3'b101: begin p.hi = 3'b001; p.lo = 3'b100; end
      3'b100: begin p.hi = 3'b001; p.lo = 3'b010; end
      3'b110: begin p.hi = 3'b100; p.lo = 3'b010; end
      3'b010: begin p.hi = 3'b100; p.lo = 3'b001; end
      3'b011: begin p.hi = 3'b010; p.lo = 3'b001; end
      3'b001: begin p.hi = 3'b010; p.lo = 3'b100; end
      default: ;
    endcase
    return p;
  endfunction

  function automatic pair_t orient(input pair_t p, input logic rev);
    pair_t q;
    q.hi = rev ? p.lo : p.hi;
    q.lo = rev ? p.hi : p.lo;
    return q;
  endfunction

  function automatic logic code_valid(input logic [CODE_W-1:0] code);
    return (code != '0) && (code != '1);
  endfunction
endpackage

// File: rtl/hall_decoder.sv
module hall_decoder
  import bldc_pkg::*;
(
  input  logic [CODE_W-1:0] hall,
  input  logic              dir_rev,
  output pair_t             pair,
  output logic              valid
);
  always_comb begin
    valid = code_valid(hall);
    pair  = orient(decode_forward(hall), dir_rev);
  end
endmodule

// File: rtl/chop_latch.sv
module chop_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_flag,
  input  logic cycle_start,
  output logic oc_hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           oc_hold <= 1'b0;
    else if (oc_flag)     oc_hold <= 1'b1;
    else if (cycle_start) oc_hold <= 1'b0;
  end
endmodule

// File: rtl/phase_gate.sv
module phase_gate
  import bldc_pkg::*;
(
  input  pair_t  pair,
  input  logic   valid,
  input  logic   brake,
  input  logic   kill,
  input  logic   quad_mode,
  input  logic   chop_off,
  output phase_t hi_next,
  output phase_t lo_next
);
  logic hi_chop;
  assign hi_chop = quad_mode & chop_off;

  for (genvar i = 0; i < PHASES; i++) begin : g_phase
    assign hi_next[i] = !kill && !brake && valid && pair.hi[i] && !hi_chop;
    assign lo_next[i] = !kill && !chop_off && (brake || (valid && pair.lo[i]));
  end
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
  import bldc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  hall,
  input  logic        dir_rev,
  input  logic        brake,
  input  logic        coast,
  input  logic        quad_mode,
  input  logic        pwm_on,
  input  logic        oc_flag,
  input  logic        uvlo,
  input  logic        cycle_start,
  output logic [2:0]  hi_drv,
  output logic [2:0]  lo_drv
);
  pair_t  pair;
  logic   valid;
  logic   oc_hold;
  logic   chop_off;
  logic   kill;
  phase_t hi_next;
  phase_t lo_next;

  hall_decoder u_dec (
    .hall(hall), .dir_rev(dir_rev), .pair(pair), .valid(valid)
  );

  chop_latch u_oc (
    .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag),
    .cycle_start(cycle_start), .oc_hold(oc_hold)
  );

  assign chop_off = !pwm_on || oc_flag || oc_hold;
  assign kill     = coast || uvlo;

  phase_gate u_gate (
    .pair(pair), .valid(valid), .brake(brake), .kill(kill),
    .quad_mode(quad_mode), .chop_off(chop_off),
    .hi_next(hi_next), .lo_next(lo_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_drv <= '0;
      lo_drv <= '0;
    end else begin
      hi_drv <= hi_next;
      lo_drv <= lo_next;
    end
  end
endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] hall,
  input logic       brake,
  input logic       coast,
  input logic       quad_mode,
  input logic       pwm_on,
  input logic       oc_flag,
  input logic       uvlo,
  input logic       cycle_start,
  input logic       oc_hold,
  input logic [2:0] hi_drv,
  input logic [2:0] lo_drv
);
  logic bad_code;
  assign bad_code = (hall == 3'b000) || (hall == 3'b111);

  p_coast_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    coast |=> (hi_drv == 3'b000 && lo_drv == 3'b000));

  p_uvlo_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (hi_drv == 3'b000 && lo_drv == 3'b000));

  p_brake_hi_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    brake |=> (hi_drv == 3'b000));

  p_invalid_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_code && !brake) |=> (hi_drv == 3'b000 && lo_drv == 3'b000));

  p_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !brake |=> ($onehot0(hi_drv) && $onehot0(lo_drv)));

  p_no_shoot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_drv & lo_drv) == 3'b000);

  p_oc_low_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |=> (lo_drv == 3'b000));

  p_oc_hold_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |=> oc_hold);

  p_oc_hold_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && !oc_flag) |=> !oc_hold);

  p_quad0_keep_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!quad_mode && !pwm_on && !bad_code && !brake && !coast && !uvlo)
      |=> ($countones(hi_drv) == 1 && lo_drv == 3'b000));

  p_quad1_all_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_mode && !pwm_on) |=> (hi_drv == 3'b000 && lo_drv == 3'b000));
endmodule

bind bldc_commutator bldc_commutator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hall(hall), .brake(brake), .coast(coast),
  .quad_mode(quad_mode), .pwm_on(pwm_on), .oc_flag(oc_flag), .uvlo(uvlo),
  .cycle_start(cycle_start), .oc_hold(oc_hold),
  .hi_drv(hi_drv), .lo_drv(lo_drv)
);

// File: tb/test_bldc_commutator.sv
module test_bldc_commutator;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hall = 3'b101;
  logic dir_rev = 1'b0, brake = 1'b0, coast = 1'b0, quad_mode = 1'b0;
  logic pwm_on = 1'b1, oc_flag = 1'b0, uvlo = 1'b0, cycle_start = 1'b0;
  logic [2:0] hi_drv, lo_drv;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bldc_commutator i_bldc_commutator (
    .clk(clk), .rst_n(rst_n), .hall(hall), .dir_rev(dir_rev), .brake(brake),
    .coast(coast), .quad_mode(quad_mode), .pwm_on(pwm_on), .oc_flag(oc_flag),
    .uvlo(uvlo), .cycle_start(cycle_start), .hi_drv(hi_drv), .lo_drv(lo_drv)
  );

  // rotation order and phase index (0=A,1=B,2=C) of the driven pair
  function automatic logic [5:0] model(input logic [2:0] code, input logic rev,
                                       input logic brk, input logic off,
                                       input logic chop, input logic quad);
    logic [2:0] seq [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    int src [6] = '{0, 0, 2, 2, 1, 1};
    int snk [6] = '{2, 1, 1, 0, 0, 2};
    logic [2:0] h = 3'b000, l = 3'b000;
    if (off) return 6'b0;
    if (brk) return {3'b000, chop ? 3'b000 : 3'b111};
    for (int k = 0; k < 6; k++) begin
      if (seq[k] == code) begin
        h[rev ? snk[k] : src[k]] = 1'b1;
        l[rev ? src[k] : snk[k]] = 1'b1;
      end
    end
    if (chop) begin
      l = 3'b000;
      if (quad) h = 3'b000;
    end
    return {h, l};
  endfunction

  task automatic check(input string req, input logic [2:0] eh, input logic [2:0] el);
    checks++;
    if (hi_drv !== eh || lo_drv !== el) begin
      fails++;
      $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", req, hi_drv, lo_drv, eh, el);
    end
    if (!brake && (($countones(hi_drv) > 1) || ($countones(lo_drv) > 1) || ((hi_drv & lo_drv) != 0))) begin
      fails++;
      $display("FAIL R12: hi=%b lo=%b expected one-hot and disjoint", hi_drv, lo_drv);
    end
  endtask

  // inputs already set; advance one edge and compare with the model
  task automatic step_model(input string req);
    logic [5:0] e;
    e = model(hall, dir_rev, brake, coast || uvlo, !pwm_on, quad_mode);
    @(posedge clk); #(CLK_PERIOD/4);
    check(req, e[5:3], e[2:0]);
  endtask

  task automatic tick;
    @(posedge clk); #(CLK_PERIOD/4);
  endtask

  task automatic t_reset;
    rst_n = 0;
    #(CLK_PERIOD*2);
    check("R11", 3'b000, 3'b000);
    @(posedge clk); #(CLK_PERIOD/4);
    rst_n = 1;
  endtask

  task automatic t_forward;
    logic [2:0] codes [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    dir_rev = 0; pwm_on = 1;
    foreach (codes[k]) begin hall = codes[k]; step_model("R1"); end
    hall = 3'b101; tick; check("R1 A-C", 3'b001, 3'b100);
    hall = 3'b011; tick; check("R1 B-A", 3'b010, 3'b001);
  endtask

  task automatic t_reverse;
    dir_rev = 1;
    for (int c = 1; c < 7; c++) begin hall = 3'(c); step_model("R2"); end
    hall = 3'b110; tick; check("R2 B-C", 3'b010, 3'b100);
    dir_rev = 0;
  endtask

  task automatic t_invalid;
    hall = 3'b000; tick; check("R3 000", 3'b000, 3'b000);
    hall = 3'b111; tick; check("R3 111", 3'b000, 3'b000);
    dir_rev = 1; hall = 3'b111; tick; check("R3 rev", 3'b000, 3'b000);
    dir_rev = 0; hall = 3'b100;
  endtask

  task automatic t_brake;
    brake = 1;
    hall = 3'b100; tick; check("R4", 3'b000, 3'b111);
    hall = 3'b000; quad_mode = 1; tick; check("R4 invalid quad1", 3'b000, 3'b111);
    pwm_on = 0; tick; check("R5 pwm off quad1", 3'b000, 3'b000);
    quad_mode = 0; tick; check("R5 pwm off quad0", 3'b000, 3'b000);
    pwm_on = 1; oc_flag = 1; tick; check("R5 overcurrent", 3'b000, 3'b000);
    oc_flag = 0; cycle_start = 1; tick; check("R5 hold", 3'b000, 3'b000);
    cycle_start = 0; tick; check("R4 after strobe", 3'b000, 3'b111);
    brake = 0; hall = 3'b100;
  endtask

  task automatic t_coast_uvlo;
    brake = 1; coast = 1; tick; check("R6 over brake", 3'b000, 3'b000);
    brake = 0; tick; check("R6 running", 3'b000, 3'b000);
    coast = 0; uvlo = 1; tick; check("R7 running", 3'b000, 3'b000);
    brake = 1; tick; check("R7 over brake", 3'b000, 3'b000);
    brake = 0; uvlo = 0; tick; check("R7 release", 3'b001, 3'b010);
  endtask

  task automatic t_chop;
    quad_mode = 0; pwm_on = 0;
    hall = 3'b010; step_model("R8");
    tick; check("R8 C-A", 3'b100, 3'b000);
    pwm_on = 1; tick; check("R8 on", 3'b100, 3'b001);
    quad_mode = 1; pwm_on = 0; tick; check("R9", 3'b000, 3'b000);
    dir_rev = 1; step_model("R9 rev");
    pwm_on = 1; tick; check("R9 on", 3'b001, 3'b100);
    dir_rev = 0; quad_mode = 0;
  endtask

  task automatic t_overcurrent;
    hall = 3'b001; quad_mode = 0; pwm_on = 1;
    oc_flag = 1; tick; check("R10 trip", 3'b010, 3'b000);
    oc_flag = 0; tick; check("R10 held", 3'b010, 3'b000);
    tick; check("R10 held2", 3'b010, 3'b000);
    cycle_start = 1; tick; check("R10 strobe edge", 3'b010, 3'b000);
    cycle_start = 0; tick; check("R10 released", 3'b010, 3'b100);
    quad_mode = 1; oc_flag = 1; cycle_start = 1; tick; check("R10 quad1 trip", 3'b000, 3'b000);
    oc_flag = 0; cycle_start = 0; tick; check("R10 survives strobe", 3'b000, 3'b000);
    cycle_start = 1; tick; cycle_start = 0; tick;
    check("R10 quad1 released", 3'b010, 3'b100);
    quad_mode = 0;
  endtask

  initial begin
    #(CLK_PERIOD/4);
    t_reset;
    t_forward;
    t_reverse;
    t_invalid;
    t_brake;
    t_coast_uvlo;
    t_chop;
    t_overcurrent;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule